// File: doc/BRIEF.md
# System Control Port Block with I/O Window Remap

This block is a byte-wide register file that answers a handful of legacy I/O ports on a workstation bridge. A simple synchronous register bus presents an address, write data, and single-cycle write and read strobes. Writes to the control ports drive level outputs for soft reset, little-endian mode and a status lamp. Writes to two ports fire one-cycle toggle pulses toward an external non-volatile memory lock. The block also holds a control nibble, two scratch bytes and a one-bit I/O map mode. Reads return either this stored state or fixed identification bytes.

The map mode also steers a combinational address translator. A CPU address that falls inside the 8 MB I/O window at 0x80000000 is turned into an ISA port address. In flat mode the port is the low 16 bits of the window offset. In dense mode the translator packs the offset of each 4 KB page together with its lowest 32 bytes, so that widely spaced pages land on consecutive 32-byte port groups.

Top module: `sysport_ctl`

## Requirements
- R1: After reset every output is 0, and the stored control nibble, the map mode and both scratch bytes read back as 0.
- R2: A write to port 0x0092 sets `soft_reset` to data bit 0 and `little_endian` to data bit 1, effective after the write edge. Both are levels that keep their value until the next write to 0x0092.
- R3: A read of port 0x0092 returns 0x00.
- R4: Port 0x081C keeps only bits [3:0] of a written byte and reads back as {4'b0, nibble}.
- R5: Port 0x0850 keeps bit 0 as the map mode (0 = flat, 1 = dense) and reads back as {7'b0, mode}.
- R6: A write to port 0x0808 sets `lamp_on` to data bit 0.
- R7: Any write to 0x0810 raises `lock_pulse_a`, and any write to 0x0812 raises `lock_pulse_b`, for exactly the one cycle after the write edge. The two pulses are never high together.
- R8: Identification reads return fixed bytes: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00 and 0x0823 gives 0x03.
- R9: Writes to 0x0800, 0x0802 and 0x0803 change no output and no readable value.
- R10: A read of any other address, including 0x0808, 0x0812 and 0x0814, returns 0xFF. A write to such an address changes nothing.
- R11: Ports 0x0398 and 0x0399 are two independent 8-bit read/write scratch bytes.
- R12: `win_hit` is 1 exactly when 0x80000000 <= `cpu_addr` < 0x80800000. When `win_hit` is 0, `port_addr` is 0.
- R13: With map mode 0 and a window hit, `port_addr` = offset & 0xFFFF.
- R14: With map mode 1 and a window hit, `port_addr` = (offset & 0x1F) | ((offset & 0x7FFF000) >> 7).

Read data is registered: `reg_rdata` takes the selected value at the clock edge where `reg_re` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Port address of the register access |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one access per high cycle |
| reg_re | input | 1 | Read strobe, one access per high cycle |
| reg_rdata | output | 8 | Registered read data |
| soft_reset | output | 1 | Soft-reset level |
| little_endian | output | 1 | Little-endian mode level |
| lamp_on | output | 1 | Status lamp level |
| lock_pulse_a | output | 1 | One-cycle lock toggle for memory region 1 |
| lock_pulse_b | output | 1 | One-cycle lock toggle for memory region 2 |
| cpu_addr | input | 32 | CPU address to translate |
| win_hit | output | 1 | Address lies in the I/O window |
| port_addr | output | 20 | Translated ISA port address |

## Verification
On every cycle the assertions check several cycle-level rules. The reset and endian levels move only after a write to 0x0092. Each lock pulse follows a write to its own port and never overlaps the other. Reads of 0x0092 return zero, and reads of the control port have a clear upper nibble. Outside the window the port address is zero, flat mode never sets bits above 15, and dense mode always keeps the lowest five address bits. The exact translated values, the identification bytes across the whole 4 KB port range, the independence of the two scratch bytes, and the fact that writes to the identification ports are ignored can only be shown by the bench. It sweeps every port address against a model of the stored state and compares translated addresses with arithmetic in both map modes.

// File: rtl/sysport_pkg.sv
package sysport_pkg;
   localparam int BYTE_W = 8;

   localparam logic [15:0] P_RST    = 16'h0092;
   localparam logic [15:0] P_SCR    = 16'h0398;
   localparam logic [15:0] P_CPUID  = 16'h0800;
   localparam logic [15:0] P_FEAT   = 16'h0802;
   localparam logic [15:0] P_STAT   = 16'h0803;
   localparam logic [15:0] P_LAMP   = 16'h0808;
   localparam logic [15:0] P_EQUIP  = 16'h080C;
   localparam logic [15:0] P_LOCK1  = 16'h0810;
   localparam logic [15:0] P_LOCK2  = 16'h0812;
   localparam logic [15:0] P_KEY    = 16'h0818;
   localparam logic [15:0] P_SYSCTL = 16'h081C;
   localparam logic [15:0] P_L2     = 16'h0823;
   localparam logic [15:0] P_MAP    = 16'h0850;

   localparam logic [7:0] ID_CPU   = 8'hEF;
   localparam logic [7:0] ID_FEAT  = 8'hAD;
   localparam logic [7:0] ID_STAT  = 8'hE0;
   localparam logic [7:0] ID_EQUIP = 8'h3C;
   localparam logic [7:0] ID_EXT   = 8'h39;
   localparam logic [7:0] ID_KEY   = 8'h00;
   localparam logic [7:0] ID_L2    = 8'h03;
   localparam logic [7:0] RD_NONE  = 8'hFF;

   localparam int SCR_N = 2;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_RST, SEL_CPUID, SEL_FEAT, SEL_STAT, SEL_EQUIP, SEL_LAMP,
      SEL_LOCK1, SEL_LOCK2, SEL_KEY, SEL_SYSCTL, SEL_L2, SEL_MAP, SEL_SCR
   } port_sel_t;
endpackage

// File: rtl/sysport_dec.sv
module sysport_dec
   import sysport_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] reg_addr,
   output port_sel_t         sel,
   output logic              scr_idx
);
   if (ADDR_W < 12) begin : g_bad_addr
      $error("sysport_dec: ADDR_W must cover the 0x800 port group");
   end

   always_comb begin
      sel = SEL_NONE;
      case (reg_addr)
         ADDR_W'(P_RST):      sel = SEL_RST;
         ADDR_W'(P_SCR):      sel = SEL_SCR;
         ADDR_W'(P_SCR + 1):  sel = SEL_SCR;
         ADDR_W'(P_CPUID):    sel = SEL_CPUID;
         ADDR_W'(P_FEAT):     sel = SEL_FEAT;
         ADDR_W'(P_STAT):     sel = SEL_STAT;
         ADDR_W'(P_LAMP):     sel = SEL_LAMP;
         ADDR_W'(P_EQUIP):    sel = SEL_EQUIP;
         ADDR_W'(P_LOCK1):    sel = SEL_LOCK1;
         ADDR_W'(P_LOCK2):    sel = SEL_LOCK2;
         ADDR_W'(P_KEY):      sel = SEL_KEY;
         ADDR_W'(P_SYSCTL):   sel = SEL_SYSCTL;
         ADDR_W'(P_L2):       sel = SEL_L2;
         ADDR_W'(P_MAP):      sel = SEL_MAP;
         default:             sel = SEL_NONE;
      endcase
   end

   assign scr_idx = reg_addr[0];
endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
   import sysport_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  port_sel_t                     sel,
   input  logic                          scr_idx,
   input  logic [BYTE_W-1:0]             wdata,
   output logic                          soft_reset_q,
   output logic                          endian_q,
   output logic                          lamp_q,
   output logic                          lock_a_q,
   output logic                          lock_b_q,
   output logic [3:0]                    sysctl_q,
   output logic                          map_q,
   output logic [SCR_N-1:0][BYTE_W-1:0]  scr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         soft_reset_q <= 1'b0;
         endian_q     <= 1'b0;
         lamp_q       <= 1'b0;
         lock_a_q     <= 1'b0;
         lock_b_q     <= 1'b0;
         sysctl_q     <= '0;
         map_q        <= 1'b0;
      end else begin
         lock_a_q <= we && (sel == SEL_LOCK1);
         lock_b_q <= we && (sel == SEL_LOCK2);
         if (we) begin
            case (sel)
               SEL_RST: begin
                  soft_reset_q <= wdata[0];
                  endian_q     <= wdata[1];
               end
               SEL_LAMP:   lamp_q   <= wdata[0];
               SEL_SYSCTL: sysctl_q <= wdata[3:0];
               SEL_MAP:    map_q    <= wdata[0];
               default: ;
            endcase
         end
      end
   end

   for (genvar i = 0; i < SCR_N; i++) begin : g_scr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            scr_q[i] <= '0;
         end else if (we && (sel == SEL_SCR) && (int'(scr_idx) == i)) begin
            scr_q[i] <= wdata;
         end
      end
   end
endmodule

// File: rtl/sysport_rdmux.sv
module sysport_rdmux
   import sysport_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          re,
   input  port_sel_t                     sel,
   input  logic                          scr_idx,
   input  logic [3:0]                    sysctl_q,
   input  logic                          map_q,
   input  logic [SCR_N-1:0][BYTE_W-1:0]  scr_q,
   output logic [BYTE_W-1:0]             rdata
);
   logic [BYTE_W-1:0] rd_val;

   always_comb begin
      case (sel)
         SEL_RST:    rd_val = 8'h00;
         SEL_CPUID:  rd_val = ID_CPU;
         SEL_FEAT:   rd_val = ID_FEAT;
         SEL_STAT:   rd_val = ID_STAT;
         SEL_EQUIP:  rd_val = ID_EQUIP;
         SEL_LOCK1:  rd_val = ID_EXT;
         SEL_KEY:    rd_val = ID_KEY;
         SEL_L2:     rd_val = ID_L2;
         SEL_SYSCTL: rd_val = {4'b0000, sysctl_q};
         SEL_MAP:    rd_val = {7'b0000000, map_q};
         SEL_SCR:    rd_val = scr_q[scr_idx];
         default:    rd_val = RD_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= rd_val;
      end
   end
endmodule

// File: rtl/sysport_remap.sv
module sysport_remap #(
   parameter int               CPU_W    = 32,
   parameter logic [CPU_W-1:0] WIN_BASE = 32'h8000_0000,
   parameter int               WIN_LG   = 23,
   parameter int               PAGE_LG  = 12,
   parameter int               DENSE_LO = 5,
   parameter int               FLAT_W   = 16,
   parameter int               PORT_W   = 20,
   parameter bit               DENSE_EN = 1'b1
) (
   input  logic [CPU_W-1:0]  cpu_addr,
   input  logic              map_mode,
   output logic              win_hit,
   output logic [PORT_W-1:0] port_addr
);
   localparam int OFF_W = PAGE_LG + PORT_W - DENSE_LO;

   if (OFF_W < WIN_LG) begin : g_bad_off
      $error("sysport_remap: dense field narrower than window offset");
   end
   if (FLAT_W > PORT_W || FLAT_W > WIN_LG) begin : g_bad_flat
      $error("sysport_remap: FLAT_W too wide");
   end
   if (DENSE_LO > PAGE_LG || WIN_LG >= CPU_W) begin : g_bad_geom
      $error("sysport_remap: bad window geometry");
   end

   logic [OFF_W-1:0]  off;
   logic [PORT_W-1:0] flat_addr;
   logic [PORT_W-1:0] dense_addr;

   assign win_hit   = (cpu_addr[CPU_W-1:WIN_LG] == WIN_BASE[CPU_W-1:WIN_LG]);
   assign off       = OFF_W'(cpu_addr[WIN_LG-1:0]);
   assign flat_addr = PORT_W'(off[FLAT_W-1:0]);

   if (DENSE_EN) begin : g_dense
      assign dense_addr = {off[OFF_W-1:PAGE_LG], off[DENSE_LO-1:0]};
   end else begin : g_flat_only
      assign dense_addr = flat_addr;
   end

   always_comb begin
      if (!win_hit)      port_addr = '0;
      else if (map_mode) port_addr = dense_addr;
      else               port_addr = flat_addr;
   end
endmodule

// File: rtl/sysport_ctl.sv
module sysport_ctl
   import sysport_pkg::*;
#(
   parameter int               ADDR_W   = 16,
   parameter int               CPU_W    = 32,
   parameter logic [CPU_W-1:0] WIN_BASE = 32'h8000_0000,
   parameter int               WIN_LG   = 23,
   parameter int               PAGE_LG  = 12,
   parameter int               DENSE_LO = 5,
   parameter int               FLAT_W   = 16,
   parameter int               PORT_W   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   input  logic              reg_re,
   output logic [7:0]        reg_rdata,
   output logic              soft_reset,
   output logic              little_endian,
   output logic              lamp_on,
   output logic              lock_pulse_a,
   output logic              lock_pulse_b,
   input  logic [CPU_W-1:0]  cpu_addr,
   output logic              win_hit,
   output logic [PORT_W-1:0] port_addr
);
   port_sel_t                    sel;
   logic                         scr_idx;
   logic [3:0]                   sysctl_q;
   logic                         map_mode_q;
   logic [SCR_N-1:0][BYTE_W-1:0] scr_q;

   sysport_dec #(.ADDR_W(ADDR_W)) i_dec (
      .reg_addr (reg_addr),
      .sel      (sel),
      .scr_idx  (scr_idx)
   );

   sysport_regs i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (reg_we),
      .sel          (sel),
      .scr_idx      (scr_idx),
      .wdata        (reg_wdata),
      .soft_reset_q (soft_reset),
      .endian_q     (little_endian),
      .lamp_q       (lamp_on),
      .lock_a_q     (lock_pulse_a),
      .lock_b_q     (lock_pulse_b),
      .sysctl_q     (sysctl_q),
      .map_q        (map_mode_q),
      .scr_q        (scr_q)
   );

   sysport_rdmux i_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .re       (reg_re),
      .sel      (sel),
      .scr_idx  (scr_idx),
      .sysctl_q (sysctl_q),
      .map_q    (map_mode_q),
      .scr_q    (scr_q),
      .rdata    (reg_rdata)
   );

   sysport_remap #(
      .CPU_W    (CPU_W),
      .WIN_BASE (WIN_BASE),
      .WIN_LG   (WIN_LG),
      .PAGE_LG  (PAGE_LG),
      .DENSE_LO (DENSE_LO),
      .FLAT_W   (FLAT_W),
      .PORT_W   (PORT_W),
      .DENSE_EN (1'b1)
   ) i_remap (
      .cpu_addr  (cpu_addr),
      .map_mode  (map_mode_q),
      .win_hit   (win_hit),
      .port_addr (port_addr)
   );
endmodule

// File: rtl/sysport_chk.sv
module sysport_chk #(
   parameter int ADDR_W   = 16,
   parameter int DENSE_LO = 5,
   parameter int FLAT_W   = 16,
   parameter int PORT_W   = 20
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [1:0]          wbits,
   input logic                reg_we,
   input logic                reg_re,
   input logic [7:0]          reg_rdata,
   input logic                soft_reset,
   input logic                little_endian,
   input logic                lock_pulse_a,
   input logic                lock_pulse_b,
   input logic [DENSE_LO-1:0] cpu_lo,
   input logic                win_hit,
   input logic                map_mode,
   input logic [PORT_W-1:0]   port_addr
);
   logic wr_rst, wr_lock1, wr_lock2, rd_rst, rd_ctl;
   assign wr_rst   = reg_we && (reg_addr == ADDR_W'(16'h0092));
   assign wr_lock1 = reg_we && (reg_addr == ADDR_W'(16'h0810));
   assign wr_lock2 = reg_we && (reg_addr == ADDR_W'(16'h0812));
   assign rd_rst   = reg_re && (reg_addr == ADDR_W'(16'h0092));
   assign rd_ctl   = reg_re && (reg_addr == ADDR_W'(16'h081C));

   // R2
   rst_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_rst) |-> ($stable(soft_reset) && $stable(little_endian)));

   // R2
   rst_level_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_rst) |-> (soft_reset == $past(wbits[0]) && little_endian == $past(wbits[1])));

   // R3
   rst_port_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_rst) |-> (reg_rdata == 8'h00));

   // R4
   ctl_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_ctl) |-> (reg_rdata[7:4] == 4'h0));

   // R7
   lock_a_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_pulse_a |-> $past(wr_lock1));

   // R7
   lock_b_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_pulse_b |-> $past(wr_lock2));

   // R7
   lock_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lock_pulse_a, lock_pulse_b}));

   // R12
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |-> (port_addr == '0));

   // R13
   flat_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && !map_mode) |-> ((port_addr >> FLAT_W) == '0));

   // R14
   dense_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && map_mode) |-> (port_addr[DENSE_LO-1:0] == cpu_lo));
endmodule

bind sysport_ctl sysport_chk #(
   .ADDR_W   (ADDR_W),
   .DENSE_LO (DENSE_LO),
   .FLAT_W   (FLAT_W),
   .PORT_W   (PORT_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_addr      (reg_addr),
   .wbits         (reg_wdata[1:0]),
   .reg_we        (reg_we),
   .reg_re        (reg_re),
   .reg_rdata     (reg_rdata),
   .soft_reset    (soft_reset),
   .little_endian (little_endian),
   .lock_pulse_a  (lock_pulse_a),
   .lock_pulse_b  (lock_pulse_b),
   .cpu_lo        (cpu_addr[DENSE_LO-1:0]),
   .win_hit       (win_hit),
   .map_mode      (map_mode_q),
   .port_addr     (port_addr)
);

// File: tb/test_sysport_ctl.sv
module test_sysport_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [7:0]  reg_rdata;
   logic        soft_reset, little_endian, lamp_on, lock_pulse_a, lock_pulse_b;
   logic [31:0] cpu_addr = '0;
   logic        win_hit;
   logic [19:0] port_addr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // model of the stored state, from the requirements
   logic [3:0] m_ctl = '0;
   logic       m_map = 1'b0;
   logic [7:0] m_scr0 = '0;
   logic [7:0] m_scr1 = '0;

   always #5 clk = ~clk;

   sysport_ctl i_sysport_ctl (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_we (reg_we), .reg_re (reg_re), .reg_rdata (reg_rdata),
      .soft_reset (soft_reset), .little_endian (little_endian), .lamp_on (lamp_on),
      .lock_pulse_a (lock_pulse_a), .lock_pulse_b (lock_pulse_b),
      .cpu_addr (cpu_addr), .win_hit (win_hit), .port_addr (port_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      @(negedge clk);
      reg_re = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      case (a)
         16'h0092: return 8'h00;
         16'h0398: return m_scr0;
         16'h0399: return m_scr1;
         16'h0800: return 8'hEF;
         16'h0802: return 8'hAD;
         16'h0803: return 8'hE0;
         16'h080C: return 8'h3C;
         16'h0810: return 8'h39;
         16'h0818: return 8'h00;
         16'h0823: return 8'h03;
         16'h081C: return {4'h0, m_ctl};
         16'h0850: return {7'h0, m_map};
         default:  return 8'hFF;
      endcase
   endfunction

   task automatic sweep(input string tag);
      logic [7:0] v;
      for (int a = 0; a < 4096; a++) begin
         rd(16'(a), v);
         chk(tag, {24'h0, v}, {24'h0, exp_rd(16'(a))});
      end
      rd(16'hF092, v);
      chk("R10 aliased high address", {24'h0, v}, 32'hFF);
   endtask

   function automatic logic [19:0] exp_port(input logic [31:0] ca, input logic mode);
      logic [31:0] off;
      if (ca < 32'h8000_0000 || ca >= 32'h8080_0000) return 20'h0;
      off = ca - 32'h8000_0000;
      if (!mode) return 20'(off % 32'h1_0000);
      return 20'((off & 32'h1F) | ((off & 32'h07FF_F000) >> 7));
   endfunction

   task automatic remap_probe(input logic [31:0] ca, input logic mode, input string tag);
      logic eh;
      cpu_addr = ca;
      #1;
      eh = (ca >= 32'h8000_0000) && (ca < 32'h8080_0000);
      chk("R12 window hit", {31'h0, win_hit}, {31'h0, eh});
      chk(tag, {12'h0, port_addr}, {12'h0, exp_port(ca, mode)});
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", {24'h0, reg_rdata}, 0);
      chk("R1 outputs", {27'h0, soft_reset, little_endian, lamp_on, lock_pulse_a, lock_pulse_b}, 0);
      rst_n = 1'b1;
      chk("R1 map mode flat", {12'h0, port_addr}, 0);
      sweep("R1 R8 R10 reset sweep");

      // R2 all four bit patterns
      for (int k = 0; k < 4; k++) begin
         wr(16'h0092, 8'(8'hF0 | k));
         chk("R2 soft_reset", {31'h0, soft_reset}, k & 1);
         chk("R2 little_endian", {31'h0, little_endian}, (k >> 1) & 1);
         @(negedge clk);
         chk("R2 level held", {30'h0, little_endian, soft_reset}, k);
      end
      rd(16'h0092, v);
      chk("R3 read 0x92", {24'h0, v}, 0);

      // R4
      wr(16'h081C, 8'hA7); m_ctl = 4'h7;
      rd(16'h081C, v); chk("R4 ctl nibble", {24'h0, v}, 32'h07);
      wr(16'h081C, 8'hFF); m_ctl = 4'hF;
      rd(16'h081C, v); chk("R4 ctl nibble", {24'h0, v}, 32'h0F);

      // R6
      wr(16'h0808, 8'h01); chk("R6 lamp on", {31'h0, lamp_on}, 1);
      wr(16'h0808, 8'hFE); chk("R6 lamp off", {31'h0, lamp_on}, 0);

      // R7 pulses
      wr(16'h0810, 8'h00);
      chk("R7 pulse a", {30'h0, lock_pulse_a, lock_pulse_b}, 2);
      @(negedge clk);
      chk("R7 pulse a one cycle", {30'h0, lock_pulse_a, lock_pulse_b}, 0);
      wr(16'h0812, 8'h5C);
      chk("R7 pulse b", {30'h0, lock_pulse_a, lock_pulse_b}, 1);
      @(negedge clk);
      chk("R7 pulse b one cycle", {30'h0, lock_pulse_a, lock_pulse_b}, 0);

      // R11 scratch
      wr(16'h0398, 8'h5A); m_scr0 = 8'h5A;
      wr(16'h0399, 8'hC3); m_scr1 = 8'hC3;
      rd(16'h0398, v); chk("R11 scratch 0", {24'h0, v}, 32'h5A);
      rd(16'h0399, v); chk("R11 scratch 1", {24'h0, v}, 32'hC3);

      // R9 and R10: ignored writes
      wr(16'h0092, 8'h03);
      wr(16'h0808, 8'h01);
      wr(16'h0800, 8'h00);
      wr(16'h0802, 8'h00);
      wr(16'h0803, 8'h00);
      wr(16'h0814, 8'h00);
      wr(16'h0823, 8'h00);
      chk("R9 R10 outputs unchanged", {29'h0, soft_reset, little_endian, lamp_on}, 7);
      sweep("R4 R8 R9 R10 R11 sweep after writes");

      // R5 and R13 flat mode
      rd(16'h0850, v); chk("R5 map reads 0", {24'h0, v}, 0);
      remap_probe(32'h8000_0000, 1'b0, "R13 flat base");
      remap_probe(32'h807F_FFFF, 1'b0, "R13 flat top");
      remap_probe(32'h7FFF_FFFF, 1'b0, "R12 below window");
      remap_probe(32'h8080_0000, 1'b0, "R12 above window");
      for (int k = 0; k < 256; k++)
         remap_probe(32'h8000_0000 + ((k * 32'h0002_9A35) & 32'h007F_FFFF), 1'b0, "R13 flat");

      wr(16'h0850, 8'hFF); m_map = 1'b1;
      rd(16'h0850, v); chk("R5 map reads 1", {24'h0, v}, 1);
      remap_probe(32'h8000_0000, 1'b1, "R14 dense base");
      remap_probe(32'h807F_FFFF, 1'b1, "R14 dense top");
      remap_probe(32'h8000_1FE3, 1'b1, "R14 dense page 1");
      remap_probe(32'h0000_0000, 1'b1, "R12 far below");
      remap_probe(32'hC000_0000, 1'b1, "R12 far above");
      for (int k = 0; k < 256; k++)
         remap_probe(32'h8000_0000 + ((k * 32'h0003_17C9) & 32'h007F_FFFF), 1'b1, "R14 dense");

      wr(16'h0850, 8'h02); m_map = 1'b0;
      rd(16'h0850, v); chk("R5 map bit0 only", {24'h0, v}, 0);
      remap_probe(32'h8012_3456, 1'b0, "R13 flat after return");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule